// File: doc/BRIEF.md
# RTC Alarm And Interrupt Controller

This block gathers the three interrupt causes of a real-time clock (a programmable periodic tick, a calendar alarm and a power-fail warning) into a small flags byte and a single active-low interrupt request. The periodic source divides a 32.768 kHz clock-enable pulse by a power of two chosen by a 4-bit rate code. The alarm source compares the current seconds, minutes, hours and date with four alarm bytes once per second. Each alarm byte carries two mask bits, so the alarm can fire every second, every minute, every hour, every day or once a month.

A control register holds the rate code and four enable bits. Software polls or services the interrupt by reading the flags. That read empties every flag at once and releases the request. A battery-mode input changes the gating: while on backup, only an alarm can pull the request low, and only when the battery-alarm enable is also set. A power-on reset input clears the alarm and power-fail enables. Flags keep recording events during that reset.

A two-state mode machine follows the supply. `MODE_MAIN` moves to `MODE_BACKUP` on the clock edge that samples `batt_mode` high (transition *enter backup*). It returns to `MODE_MAIN` on the edge that samples it low (transition *leave backup*). The state only selects how flags and enables combine into `irq_n`.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: While `rst_n` is low, `flags` reads 0x00 and `irq_n` is 1, and the control register is all zero (rate code 0, every enable off).
- R2: With rate code n in `ctl_wdata[3:0]` (n = 1..15), the periodic flag (`flags[0]`) is set on a `base_tick` pulse if the count of `base_tick` pulses since reset, taken modulo 2^(n-1), equals 2^(n-1)-1. The period is therefore 2^(n-1) ticks, which is 30.5 us for n = 1 and 500 ms for n = 15. Rate code 0 never sets the flag.
- R3: An alarm byte is masked (always matches) when its bits 7 and 6 are both 1. Otherwise only bits 5:0 are compared with the current-time byte. Bytes sit in `cur_time`/`alm_time` as [7:0] seconds, [15:8] minutes, [23:16] hours, [31:24] date.
- R4: The alarm flag (`flags[1]`) is set only in a cycle with `upd_tick` high, and only when every unmasked alarm byte matches.
- R5: A `pf_evt` pulse sets the power-fail flag (`flags[2]`). Flag bits 7:3 always read 0.
- R6: In `MODE_MAIN`, `irq_n` is 0 exactly when some flag is set together with its enable: periodic with `ctl[4]`, alarm with `ctl[5]`, power-fail with `ctl[6]`.
- R7: `flags_rd` clears every flag at once. An event in the same cycle as the read is set after the clear, so it is not lost.
- R8: In `MODE_BACKUP`, `irq_n` is 0 only when the alarm flag, `ctl[5]` and the battery-alarm enable `ctl[7]` are all set.
- R9: While `por` is high, `ctl[5]` and `ctl[6]` are forced to 0, even against a write in the same cycle. An alarm match during `por` still sets the alarm flag.
- R10: `ctl_we` loads `ctl_wdata` into the control register on the next edge, and `flags`/`irq_n` reflect every input sampled at an edge right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_tick | input | 1 | One-cycle pulse at 32.768 kHz |
| upd_tick | input | 1 | Once-per-second update strobe |
| cur_time | input | 32 | Current BCD date, hour, minute, second |
| alm_time | input | 32 | Alarm bytes with mask bits 7:6 |
| pf_evt | input | 1 | Power-fail detection pulse |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control data: rate[3:0], periodic en[4], alarm en[5], power-fail en[6], battery-alarm en[7] |
| flags_rd | input | 1 | Flags read strobe (clears all flags) |
| por | input | 1 | Power-on reset in progress |
| batt_mode | input | 1 | Running from backup battery |
| flags | output | 8 | Event flags: periodic[0], alarm[1], power-fail[2] |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Every result is due one clock edge after the stimulus that causes it. An event, a read, a control write, a `por` level or a `batt_mode` change is sampled at a rising edge. The new `flags` and `irq_n` are visible right after that edge, because `irq_n` is decoded without a register from the flag, enable and mode registers. The bench drives all inputs on the falling edge, lets exactly one rising edge pass, and compares at the following falling edge against a model that takes the same one-edge step. The directed cases aimed at the same-cycle read and event, the alarm mask patterns and the backup gating are therefore judged in the very cycle they are due.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
    localparam int RATE_W   = 4;
    localparam int PRE_W    = (1 << RATE_W) - 2;
    localparam int NBYTES   = 4;
    localparam int FLAG_W   = 3;
    localparam int CTL_W    = 8;

    localparam int FL_PER   = 0;
    localparam int FL_ALM   = 1;
    localparam int FL_PWR   = 2;

    localparam int EN_PER   = 4;
    localparam int EN_ALM   = 5;
    localparam int EN_PWR   = 6;
    localparam int EN_BAT   = 7;

    typedef enum logic {
        MODE_MAIN   = 1'b0,
        MODE_BACKUP = 1'b1
    } mode_e;
endpackage

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
    parameter int NBYTES = 4
) (
    input  logic                  upd_tick,
    input  logic [8*NBYTES-1:0]   cur_time,
    input  logic [8*NBYTES-1:0]   alm_time,
    output logic                  alarm_hit
);
    logic [NBYTES-1:0] byte_ok;

    for (genvar gi = 0; gi < NBYTES; gi++) begin : g_byte
        logic masked;
        assign masked      = &alm_time[8*gi+6 +: 2];
        assign byte_ok[gi] = masked || (alm_time[8*gi +: 6] == cur_time[8*gi +: 6]);
    end

    assign alarm_hit = upd_tick && (&byte_ok);
endmodule

// File: rtl/rtc_periodic_gen.sv
module rtc_periodic_gen #(
    parameter int RATE_W = 4,
    parameter int PRE_W  = (1 << RATE_W) - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_tick,
    input  logic [RATE_W-1:0] rate,
    output logic              per_evt
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] sel_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         pre_q <= '0;
        else if (base_tick) pre_q <= pre_q + 1'b1;
    end

    always_comb begin
        sel_mask = '0;
        for (int k = 0; k < PRE_W; k++) begin
            if (k < int'(rate) - 1) sel_mask[k] = 1'b1;
        end
    end

    assign per_evt = base_tick && (rate != '0) && ((pre_q & sel_mask) == sel_mask);
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
    import rtc_irq_pkg::*;
#(
    parameter int NB = NBYTES
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            base_tick,
    input  logic            upd_tick,
    input  logic [8*NB-1:0] cur_time,
    input  logic [8*NB-1:0] alm_time,
    input  logic            pf_evt,
    input  logic            ctl_we,
    input  logic [7:0]      ctl_wdata,
    input  logic            flags_rd,
    input  logic            por,
    input  logic            batt_mode,
    output logic [7:0]      flags,
    output logic            irq_n
);
    mode_e             mode_q, mode_d;
    logic [CTL_W-1:0]  ctl_q, ctl_d;
    logic [FLAG_W-1:0] flg_q, flg_d, evt;
    logic              per_evt, alarm_hit;

    rtc_periodic_gen #(.RATE_W(RATE_W), .PRE_W(PRE_W)) u_per (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_tick (base_tick),
        .rate      (ctl_q[RATE_W-1:0]),
        .per_evt   (per_evt)
    );

    rtc_alarm_cmp #(.NBYTES(NB)) u_alm (
        .upd_tick  (upd_tick),
        .cur_time  (cur_time),
        .alm_time  (alm_time),
        .alarm_hit (alarm_hit)
    );

    // mode machine: next state
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_MAIN:   if (batt_mode)  mode_d = MODE_BACKUP;
            MODE_BACKUP: if (!batt_mode) mode_d = MODE_MAIN;
        endcase
    end

    // control register and flags next values
    always_comb begin
        ctl_d = ctl_we ? ctl_wdata : ctl_q;
        if (por) begin
            ctl_d[EN_ALM] = 1'b0;
            ctl_d[EN_PWR] = 1'b0;
        end
        evt          = '0;
        evt[FL_PER]  = per_evt;
        evt[FL_ALM]  = alarm_hit;
        evt[FL_PWR]  = pf_evt;
        flg_d        = (flags_rd ? '0 : flg_q) | evt;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_MAIN;
            ctl_q  <= '0;
            flg_q  <= '0;
        end else begin
            mode_q <= mode_d;
            ctl_q  <= ctl_d;
            flg_q  <= flg_d;
        end
    end

    // outputs
    always_comb begin
        flags = {{(8-FLAG_W){1'b0}}, flg_q};
        unique case (mode_q)
            MODE_MAIN:   irq_n = !((flg_q[FL_PER] && ctl_q[EN_PER]) ||
                                   (flg_q[FL_ALM] && ctl_q[EN_ALM]) ||
                                   (flg_q[FL_PWR] && ctl_q[EN_PWR]));
            MODE_BACKUP: irq_n = !(flg_q[FL_ALM] && ctl_q[EN_ALM] && ctl_q[EN_BAT]);
        endcase
    end
endmodule

// File: rtl/rtc_irq_chk.sv
module rtc_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       base_tick,
    input logic       upd_tick,
    input logic       pf_evt,
    input logic       flags_rd,
    input logic       por,
    input logic       batt_mode,
    input logic [7:0] ctl_q,
    input logic [7:0] flags,
    input logic       irq_n
);
    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_state_chk: assert (irq_n && flags == 8'h00);
        end
    end

    // R2
    per_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[0]) |-> $past(base_tick));

    // R4
    alarm_needs_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[1]) |-> $past(upd_tick));

    // R5
    pwr_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pf_evt |=> flags[2] && flags[7:3] == 5'b0);

    // R6
    irq_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> flags != 8'h00);

    // R7
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags_rd && !base_tick && !upd_tick && !pf_evt |=> flags == 8'h00);

    // R8
    backup_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(batt_mode) && !flags[1] |-> irq_n);

    // R9
    por_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        por |=> !ctl_q[5] && !ctl_q[6]);
endmodule

bind rtc_irq_ctrl rtc_irq_chk u_chk (.*);

// File: tb/rtc_irq_ctrl_test.sv
module rtc_irq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_tick = 0, upd_tick = 0, pf_evt = 0, ctl_we = 0, flags_rd = 0, por = 0, batt_mode = 0;
    logic [31:0] cur_time = '0, alm_time = '0;
    logic [7:0]  ctl_wdata = '0;
    logic [7:0]  flags;
    logic        irq_n;

    int checks = 0, fails = 0;
    bit done = 0;

    logic [2:0]  m_flg = '0;
    logic [7:0]  m_ctl = '0;
    int          m_cnt = 0;
    logic        m_bat = 0;

    always #5 clk = ~clk;

    rtc_irq_ctrl uut (.*);

    function automatic bit alarm_match(logic [31:0] c, logic [31:0] a);
        for (int b = 0; b < 4; b++) begin
            if (!(a[8*b+7] && a[8*b+6]) && (a[8*b +: 6] != c[8*b +: 6])) return 0;
        end
        return 1;
    endfunction

    function automatic bit exp_irq();
        if (m_bat) return !(m_flg[1] && m_ctl[5] && m_ctl[7]);
        return !((m_flg[0] && m_ctl[4]) || (m_flg[1] && m_ctl[5]) || (m_flg[2] && m_ctl[6]));
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(string tag);
        int per_len;
        bit ev_p, ev_a;
        @(posedge clk);
        per_len = (m_ctl[3:0] == 0) ? 0 : (1 << (m_ctl[3:0] - 1));
        ev_p = base_tick && per_len != 0 && ((m_cnt % per_len) == per_len - 1);
        if (base_tick) m_cnt = (m_cnt + 1) % (1 << 14);
        ev_a = upd_tick && alarm_match(cur_time, alm_time);
        m_flg = (flags_rd ? 3'b000 : m_flg) | {pf_evt, ev_a, ev_p};
        if (ctl_we) m_ctl = ctl_wdata;
        if (por) begin m_ctl[5] = 0; m_ctl[6] = 0; end
        m_bat = batt_mode;
        @(negedge clk);
        check({tag, " flags"}, {24'h0, flags}, {29'h0, m_flg});
        check({tag, " irq_n"}, {31'h0, irq_n}, {31'h0, exp_irq()});
        base_tick = 0; upd_tick = 0; pf_evt = 0; ctl_we = 0; flags_rd = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 flags", {24'h0, flags}, 32'h0);
        check("R1 irq_n", {31'h0, irq_n}, 32'h1);
        rst_n = 1;
        @(negedge clk);

        // R10 enable all in main mode, rate code 1
        ctl_we = 1; ctl_wdata = 8'h71; step("R10");
        // R2 periodic every tick at code 1
        base_tick = 1; step("R2");
        flags_rd = 1; step("R7");
        // R3 R4 once-per-minute: seconds compared, rest masked
        cur_time = 32'h0312_4530; alm_time = 32'hC0C0_C030;
        step("R4 no update");
        upd_tick = 1; step("R4 seconds match");
        flags_rd = 1; step("R7");
        alm_time = 32'hC0C0_C031; upd_tick = 1; step("R3 seconds mismatch");
        alm_time = 32'hC0C0_C0B0; upd_tick = 1; step("R3 bits 7:6 ignored");
        // R7 read with same-cycle event
        flags_rd = 1; pf_evt = 1; step("R7 same cycle");
        flags_rd = 1; step("R7");
        // R8 backup: only alarm with both enables
        batt_mode = 1; pf_evt = 1; step("R8 pf in backup");
        upd_tick = 1; step("R8 alarm in backup");
        ctl_we = 1; ctl_wdata = 8'hF0; step("R8 battery alarm enable");
        // R9 power-on reset clears alarm and pf enables
        batt_mode = 0; flags_rd = 1; por = 1; ctl_we = 1; ctl_wdata = 8'h60; step("R9 write during por");
        upd_tick = 1; step("R9 alarm during por");
        por = 0; step("R9 after por");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            base_tick = ($urandom % 2) == 0;
            upd_tick  = ($urandom % 4) == 0;
            pf_evt    = ($urandom % 20) == 0;
            flags_rd  = ($urandom % 10) == 0;
            ctl_we    = ($urandom % 25) == 0;
            ctl_wdata = 8'($urandom);
            if ($urandom % 3 == 0) ctl_wdata[3:0] = 4'($urandom % 4);
            if ($urandom % 40 == 0) por = !por;
            if ($urandom % 30 == 0) batt_mode = !batt_mode;
            for (int b = 0; b < 4; b++) begin
                cur_time[8*b +: 8] = 8'($urandom % 3);
                alm_time[8*b +: 8] = {2'($urandom), 6'($urandom % 3)};
            end
            step("R2/R3/R4/R5/R6/R8/R9 random");
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule